// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block takes the demodulated output of a consumer infrared receiver and converts it into a stream of run-length bytes. A receiver circuit hands each byte to software or a buffer, and that side rebuilds the remote-control code from the durations. The block derives a sample strobe from its reference clock using one of two divider ratios. It can invert the incoming level and passes it through a two-flop synchronizer. A glitch filter then ignores any level change that does not persist for a programmable number of samples.

A packet begins once a mark has lasted for a programmable start duration. From then on, every run of one level is reported as a byte. The top bit of the byte gives the level and the low seven bits give the length in samples. Runs longer than 127 samples are cut into several bytes. A long stretch of space closes the packet: the space run in progress is flushed as the last byte, and a one-cycle packet-end strobe follows it.

Top module: `irrx_runlen_sampler`

## Requirements
- R1: The sample strobe period is DIV_LO clock cycles when `rate_sel` is 0 and DIV_HI cycles when it is 1 (defaults 64 and 128).
- R2: The sampler operates only while `en_global` and `en_receive` are both 1 and `op_mode` equals 2'b11. Otherwise it emits no byte and no packet end, and a later re-enable starts from a cleared state.
- R3: With `pol_flip` = 0 a high `ir_raw` is a mark. With `pol_flip` = 1 a low `ir_raw` is a mark.
- R4: A level change is accepted only after F consecutive samples of the new level, where F = `glitch_len`, or 1 when `glitch_len` is 0. Shorter pulses are ignored, and their samples count toward the surrounding run.
- R5: In each output byte, bit 7 is 1 for a mark and 0 for a space. Bits 6:0 hold the run length in samples, from 1 to 127.
- R6: When a run reaches 127 samples, a byte of length 127 is emitted at once and counting restarts for the same level. A level change right after such a split emits no extra byte.
- R7: A packet starts on the A-th consecutive mark sample, where A = (`start_len` + 1) × (`start_scale` ? SCALE : 1). The first byte counts the mark from that sample.
- R8: Within a packet, after (`quiet_len` + 1) × SCALE consecutive space samples (SCALE defaults to 128), the space run is flushed as a byte and the block waits for the next packet.
- R9: `pkt_done` is high for exactly one cycle, in the cycle after the final space byte of a packet.
- R10: While reset is held, `run_valid` and `pkt_done` are low.
- R11: At most one byte is emitted per sample, so `run_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_raw | input | 1 | Demodulated infrared input, asynchronous |
| en_global | input | 1 | Block enable |
| en_receive | input | 1 | Receive path enable |
| op_mode | input | 2 | Operating mode; 2'b11 selects infrared sampling |
| rate_sel | input | 1 | Sample divider select (0: DIV_LO, 1: DIV_HI) |
| glitch_len | input | 6 | Minimum samples for a level change to be accepted |
| quiet_len | input | 8 | Idle timeout in units of SCALE samples, minus one |
| start_len | input | 7 | Packet start mark duration, minus one |
| start_scale | input | 1 | Multiplies the start duration by SCALE |
| pol_flip | input | 1 | Inverts the input level |
| run_valid | output | 1 | Byte strobe |
| run_byte | output | 8 | Level in bit 7, run length in bits 6:0 |
| pkt_done | output | 1 | Packet-end pulse |

## Verification
Two events can land on the same sample: the split of a long space run at 127 samples, and the expiry of the idle timeout. The bench provokes this by setting the idle timeout to exactly eight times 127 samples and holding space well past it. It then checks that the coinciding sample yields a single 127-length space byte rather than two, and that the packet-end pulse follows that byte by one cycle. A second case checks a mark of exactly 127 samples followed by a space: the split and the level change meet there, and no zero-length byte may appear.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
    // width of the run-length field carried in each byte
    localparam int RUN_W = 7;
    // largest run held in one byte
    localparam logic [RUN_W-1:0] RUN_MAX = 7'd127;
    // mode code that selects infrared sampling
    localparam logic [1:0] MODE_IR = 2'b11;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_PKT  = 1'b1
    } phase_e;
endpackage

// File: rtl/irrx_tick.sv
// Sample strobe generator: one-cycle tick every DIV_LO or DIV_HI clocks.
// Assumes DIV_LO >= 2 and DIV_HI >= DIV_LO; counter restarts while idle.
module irrx_tick #(
    parameter int DIV_LO = 64,
    parameter int DIV_HI = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel,
    output logic tick
);
    localparam int CW = $clog2(DIV_HI);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = sel ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    assign tick = run && (cnt >= lim);

    // count clocks within one sample period
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt >= lim) cnt <= '0;
        else                 cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/irrx_front.sv
// Input front end: polarity flip, two-flop synchronizer, glitch filter.
// The filtered level changes only after glitch_len consecutive differing
// samples (at least one). lvl_stb marks the cycle in which lvl is current.
module irrx_front (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       ir_raw,
    input  logic       flip,
    input  logic [5:0] glitch_len,
    output logic       lvl,
    output logic       lvl_stb
);
    logic       sync1, sync2;
    logic [5:0] diff_cnt;
    logic [6:0] need;

    assign need = (glitch_len == 6'd0) ? 7'd1 : {1'b0, glitch_len};

    // bring the flipped input into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= ir_raw ^ flip;
            sync2 <= sync1;
        end
    end

    // accept a new level once it has persisted long enough
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            lvl      <= 1'b0;
            diff_cnt <= '0;
            lvl_stb  <= 1'b0;
        end else begin
            lvl_stb <= tick;
            if (tick) begin
                if (sync2 != lvl) begin
                    if ({1'b0, diff_cnt} + 7'd1 >= need) begin
                        lvl      <= sync2;
                        diff_cnt <= '0;
                    end else begin
                        diff_cnt <= diff_cnt + 6'd1;
                    end
                end else begin
                    diff_cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/irrx_core.sv
// Run-length engine: waits for a qualifying mark, then reports each run as
// {level, length}, splits runs at 127, and closes the packet after a long
// space. Assumes SCALE >= 2 so a timeout never meets a level change.
module irrx_core
    import irrx_pkg::*;
#(
    parameter int SCALE = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       stb,
    input  logic       lvl,
    input  logic [7:0] quiet_len,
    input  logic [6:0] start_len,
    input  logic       start_scale,
    output logic       run_valid,
    output logic [7:0] run_byte,
    output logic       pkt_done
);
    localparam int AW = $clog2(128 * SCALE) + 1;
    localparam int QW = $clog2(256 * SCALE) + 1;

    phase_e           phase, nx_phase;
    logic             cur, nx_cur;
    logic [RUN_W-1:0] runlen, nx_run, run_inc;
    logic [AW-1:0]    qual, nx_qual, need_start;
    logic [QW-1:0]    quiet, nx_quiet, quiet_inc, need_quiet;
    logic             e_valid, e_flush, flush_d;
    logic [7:0]       e_byte;

    assign need_start = AW'({1'b0, start_len} + 8'd1) * (start_scale ? AW'(SCALE) : AW'(1));
    assign need_quiet = QW'({1'b0, quiet_len} + 9'd1) * QW'(SCALE);
    assign run_inc    = (lvl == cur) ? runlen + RUN_W'(1) : RUN_W'(1);
    assign quiet_inc  = lvl ? '0 : quiet + QW'(1);

    // decide the next state and any byte for this sample
    always_comb begin
        nx_phase = phase;
        nx_cur   = cur;
        nx_run   = runlen;
        nx_qual  = qual;
        nx_quiet = quiet;
        e_valid  = 1'b0;
        e_flush  = 1'b0;
        e_byte   = 8'd0;
        if (stb) begin
            unique case (phase)
                ST_WAIT: begin
                    if (!lvl) begin
                        nx_qual = '0;
                    end else if (qual + AW'(1) >= need_start) begin
                        nx_phase = ST_PKT;
                        nx_cur   = 1'b1;
                        nx_run   = RUN_W'(1);
                        nx_qual  = '0;
                        nx_quiet = '0;
                    end else begin
                        nx_qual = qual + AW'(1);
                    end
                end
                ST_PKT: begin
                    nx_quiet = quiet_inc;
                    if (!lvl && quiet_inc == need_quiet) begin
                        e_valid  = 1'b1;
                        e_byte   = {lvl, run_inc};
                        e_flush  = 1'b1;
                        nx_phase = ST_WAIT;
                        nx_cur   = 1'b0;
                        nx_run   = '0;
                        nx_quiet = '0;
                    end else if (lvl != cur) begin
                        e_valid = (runlen != '0);
                        e_byte  = {cur, runlen};
                        nx_cur  = lvl;
                        nx_run  = RUN_W'(1);
                    end else if (run_inc == RUN_MAX) begin
                        e_valid = 1'b1;
                        e_byte  = {cur, RUN_MAX};
                        nx_run  = '0;
                    end else begin
                        nx_run = run_inc;
                    end
                end
                default: nx_phase = ST_WAIT;
            endcase
        end
    end

    // register state and outputs; packet end trails the flushed byte
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase     <= ST_WAIT;
            cur       <= 1'b0;
            runlen    <= '0;
            qual      <= '0;
            quiet     <= '0;
            run_valid <= 1'b0;
            run_byte  <= 8'd0;
            flush_d   <= 1'b0;
            pkt_done  <= 1'b0;
        end else begin
            phase     <= nx_phase;
            cur       <= nx_cur;
            runlen    <= nx_run;
            qual      <= nx_qual;
            quiet     <= nx_quiet;
            run_valid <= e_valid;
            if (e_valid) run_byte <= e_byte;
            flush_d   <= e_flush;
            pkt_done  <= flush_d;
        end
    end
endmodule

// File: rtl/irrx_runlen_sampler.sv
// Top level: gates the sampler with the enables and mode, then chains the
// strobe generator, the input front end and the run-length engine.
module irrx_runlen_sampler
    import irrx_pkg::*;
#(
    parameter int DIV_LO = 64,
    parameter int DIV_HI = 128,
    parameter int SCALE  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_raw,
    input  logic       en_global,
    input  logic       en_receive,
    input  logic [1:0] op_mode,
    input  logic       rate_sel,
    input  logic [5:0] glitch_len,
    input  logic [7:0] quiet_len,
    input  logic [6:0] start_len,
    input  logic       start_scale,
    input  logic       pol_flip,
    output logic       run_valid,
    output logic [7:0] run_byte,
    output logic       pkt_done
);
    logic gate, tick, lvl, lvl_stb;

    assign gate = en_global && en_receive && (op_mode == MODE_IR);

    irrx_tick #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(gate), .sel(rate_sel), .tick(tick)
    );

    irrx_front u_front (
        .clk(clk), .rst_n(rst_n), .run(gate), .tick(tick), .ir_raw(ir_raw),
        .flip(pol_flip), .glitch_len(glitch_len), .lvl(lvl), .lvl_stb(lvl_stb)
    );

    irrx_core #(.SCALE(SCALE)) u_core (
        .clk(clk), .rst_n(rst_n), .run(gate), .stb(lvl_stb), .lvl(lvl),
        .quiet_len(quiet_len), .start_len(start_len), .start_scale(start_scale),
        .run_valid(run_valid), .run_byte(run_byte), .pkt_done(pkt_done)
    );
endmodule

// File: rtl/irrx_runlen_sampler_chk.sv
// Property checker bound to the sampler top; watches only its ports.
module irrx_runlen_sampler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_global,
    input logic       en_receive,
    input logic [1:0] op_mode,
    input logic       run_valid,
    input logic [7:0] run_byte,
    input logic       pkt_done
);
    // R5: every emitted byte carries a nonzero length
    p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_valid |-> run_byte[6:0] != 7'd0);

    // R2: a disabled or wrongly moded block stays silent
    p_gate_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_global && en_receive && op_mode == 2'b11) |=> !run_valid && !pkt_done);

    // R9: packet end follows a space byte by one cycle
    p_end_after_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> $past(run_valid) && !$past(run_byte[7]));

    // R9: packet end lasts one cycle
    p_end_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    // R11: no two byte strobes back to back
    p_byte_rate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run_valid |=> !run_valid);
endmodule

bind irrx_runlen_sampler irrx_runlen_sampler_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_receive(en_receive),
    .op_mode(op_mode), .run_valid(run_valid), .run_byte(run_byte), .pkt_done(pkt_done)
);

// File: tb/irrx_runlen_sampler_tb.sv
module irrx_runlen_sampler_tb;
    localparam int DLO = 8;
    localparam int DHI = 16;
    localparam int SC  = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, ir_raw, en_global, en_receive, rate_sel, start_scale, pol_flip;
    logic [1:0] op_mode;
    logic [5:0] glitch_len;
    logic [7:0] quiet_len;
    logic [6:0] start_len;
    logic       run_valid, pkt_done;
    logic [7:0] run_byte;

    irrx_runlen_sampler #(.DIV_LO(DLO), .DIV_HI(DHI), .SCALE(SC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ir_raw(ir_raw), .en_global(en_global),
        .en_receive(en_receive), .op_mode(op_mode), .rate_sel(rate_sel),
        .glitch_len(glitch_len), .quiet_len(quiet_len), .start_len(start_len),
        .start_scale(start_scale), .pol_flip(pol_flip), .run_valid(run_valid),
        .run_byte(run_byte), .pkt_done(pkt_done)
    );

    // vector table: mark a, space b, mark c, then long space; expected bytes
    localparam int NV = 4;
    localparam int TA[NV] = '{5, 126, 127, 130};
    localparam int TB[NV] = '{3, 31, 10, 4};
    localparam int TC[NV] = '{7, 1, 2, 20};
    localparam int TN[NV] = '{4, 4, 4, 5};
    localparam int TE[NV][5] = '{'{'h85, 'h03, 'h87, 'h20, 0},
                                 '{'hFE, 'h1F, 'h81, 'h20, 0},
                                 '{'hFF, 'h0A, 'h82, 'h20, 0},
                                 '{'hFF, 'h83, 'h04, 'h94, 'h20}};

    int cyc = 0;
    int cap_n = 0, ends = 0, last_cyc = 0, end_cyc = 0, prev_cyc = -1000, min_gap = 1000000;
    int checks = 0, errs = 0, exp_n = 0;
    logic [7:0] cap [0:31];
    int exp_b [0:31];

    always @(posedge clk) cyc <= cyc + 1;

    // capture outputs between edges
    always @(negedge clk) begin
        if (run_valid) begin
            if (cap_n < 32) cap[cap_n] = run_byte;
            cap_n++;
            last_cyc = cyc;
            if (cyc - prev_cyc < min_gap) min_gap = cyc - prev_cyc;
            prev_cyc = cyc;
        end
        if (pkt_done) begin
            ends++;
            end_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic hold(input bit mark, input int n);
        ir_raw = mark ^ pol_flip;
        repeat (n * (rate_sel ? DHI : DLO)) @(negedge clk);
    endtask

    task automatic restart();
        en_global = 1'b0;
        repeat (2) @(negedge clk);
        cap_n = 0;
        ends = 0;
        ir_raw = pol_flip;
        en_global = 1'b1;
        repeat ((rate_sel ? DHI : DLO) / 2) @(negedge clk);
    endtask

    task automatic check_pkt(input string tag, input int n_end);
        chk(cap_n == exp_n, {tag, " byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < 32; i++)
            chk(cap[i] == exp_b[i], $sformatf("%s byte %0d", tag, i), cap[i], exp_b[i]);
        chk(ends == n_end, {tag, " packet ends"}, ends, n_end);
        if (n_end > 0)
            chk(end_cyc == last_cyc + 1, {tag, " R9 end follows final byte"}, end_cyc, last_cyc + 1);
    endtask

    task automatic defaults();
        en_receive = 1'b1; op_mode = 2'b11; rate_sel = 1'b0; glitch_len = 6'd0;
        quiet_len = 8'd3; start_len = 7'd0; start_scale = 1'b0; pol_flip = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired before the run ended");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ir_raw = 1'b0; en_global = 1'b1;
        defaults();
        repeat (4) @(negedge clk);
        chk(run_valid == 1'b0, "R10 run_valid in reset", run_valid, 0);
        chk(pkt_done == 1'b0, "R10 pkt_done in reset", pkt_done, 0);
        rst_n = 1'b1;

        // table walk: R5 format, R6 splitting, R8 flush
        for (int v = 0; v < NV; v++) begin
            restart();
            hold(1, TA[v]); hold(0, TB[v]); hold(1, TC[v]); hold(0, 40);
            exp_n = TN[v];
            for (int i = 0; i < TN[v]; i++) exp_b[i] = TE[v][i];
            check_pkt($sformatf("R5/R6 vector %0d", v), 1);
        end

        // R2: wrong mode, receive disabled, and restart clears state
        op_mode = 2'b01; restart(); hold(1, 20); hold(0, 40);
        chk(cap_n == 0 && ends == 0, "R2 wrong mode silent", cap_n + ends, 0);
        op_mode = 2'b11; en_receive = 1'b0; restart(); hold(1, 20); hold(0, 40);
        chk(cap_n == 0 && ends == 0, "R2 receive off silent", cap_n + ends, 0);
        en_receive = 1'b1; restart(); hold(1, 10);
        restart(); hold(1, 5); hold(0, 40);
        exp_n = 2; exp_b[0] = 'h85; exp_b[1] = 'h20;
        check_pkt("R2 cleared on re-enable", 1);

        // R3: inverted input
        pol_flip = 1'b1; restart(); hold(1, 6); hold(0, 40);
        exp_n = 2; exp_b[0] = 'h86; exp_b[1] = 'h20;
        check_pkt("R3 inverted", 1);
        pol_flip = 1'b0;

        // R4: glitch filter
        glitch_len = 6'd4; restart(); hold(1, 3); hold(0, 10);
        chk(cap_n == 0 && ends == 0, "R4 short mark ignored", cap_n + ends, 0);
        hold(1, 10); hold(0, 2); hold(1, 10); hold(0, 40);
        exp_n = 2; exp_b[0] = 'h96; exp_b[1] = 'h20;
        check_pkt("R4 gap bridged", 1);
        glitch_len = 6'd0;

        // R1: slow divider
        rate_sel = 1'b1; restart(); hold(1, 9); hold(0, 40);
        exp_n = 2; exp_b[0] = 'h89; exp_b[1] = 'h20;
        check_pkt("R1 slow rate", 1);
        rate_sel = 1'b0;

        // R7: start threshold, unscaled then scaled
        start_len = 7'd2; restart(); hold(1, 2); hold(0, 5);
        chk(cap_n == 0, "R7 short lead ignored", cap_n, 0);
        hold(1, 10); hold(0, 40);
        exp_n = 2; exp_b[0] = 'h88; exp_b[1] = 'h20;
        check_pkt("R7 unscaled start", 1);
        start_len = 7'd0; start_scale = 1'b1; restart(); hold(1, 12); hold(0, 40);
        exp_n = 2; exp_b[0] = 'h85; exp_b[1] = 'h20;
        check_pkt("R7 scaled start", 1);
        start_scale = 1'b0;

        // R8: shortest timeout, two packets in a row
        quiet_len = 8'd0; restart();
        hold(1, 3); hold(0, 20); hold(1, 2); hold(0, 20);
        exp_n = 4; exp_b[0] = 'h83; exp_b[1] = 'h08; exp_b[2] = 'h82; exp_b[3] = 'h08;
        check_pkt("R8 short timeout", 2);

        // R6 and R8 on one sample: split at 127 coincides with timeout
        quiet_len = 8'd126; restart(); hold(1, 4); hold(0, 1030);
        exp_n = 9; exp_b[0] = 'h84;
        for (int i = 1; i < 9; i++) exp_b[i] = 'h7F;
        check_pkt("R6 split meets R8 timeout", 1);

        chk(min_gap >= DLO, "R11 byte spacing", min_gap, DLO);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule